// File: doc/BRIEF.md
# SDRAM Periodic Refresh Scheduler

This block decides when an SDRAM controller must refresh its memory. A counter, loaded from a programmable interval input, marks a refresh as owed each time the interval runs out. The scheduler then raises a request to the command sequencer. The sequencer grants the request, issues Precharge All followed by Auto Refresh, and pulses done. Refreshes owed while a data transfer is running, or while the memory sits in self-refresh, are held back. They are released as soon as the bus or the memory is free again.

A deferred refresh never restarts the counter, so the long-run rate matches the programmed interval. Up to two owed refreshes are remembered and served back to back. After each refresh the block keeps its in-progress flag high for a programmable recovery count before it can ask again. Clearing the enable input resets the counter, and an interval of zero stops refresh generation altogether.

Top module: `sdram_refresh_sched`

## Requirements
- R1: With enable high and a nonzero interval N, the counter marks a refresh as owed once every N cycles. The first request rises N clock edges after the first edge that samples enable high. When service completes within the interval, requests rise exactly N cycles apart.
- R2: No request rises while xfer_busy is sampled high. An owed refresh raises the request on the first edge that samples xfer_busy low.
- R3: A refresh deferred by xfer_busy does not shift the schedule. The next request still rises a whole number of intervals after the start.
- R4: While self_ref is sampled high, no request rises and expiries keep being recorded. The owed refresh is requested on the first edge that samples self_ref low.
- R5: A self-refresh stay that holds no expiry produces no extra request, and the next request keeps its normal schedule.
- R6: At most two refreshes are owed at a time. Further expiries while two are owed are dropped.
- R7: Once risen, ref_req stays high, through the grant, until the edge that samples seq_done while the refresh is granted. It is low after that edge.
- R8: ref_active is low while the request waits for a grant. It goes high on the edge that samples seq_grant and stays high through done plus gap_cycles further edges (none when gap_cycles is 0).
- R9: When a refresh is still owed after one completes, the next request rises on the first edge after recovery ends.
- R10: Sampling ref_enable low clears the interval counter. Counting restarts from zero when enable returns, and owed refreshes are kept.
- R11: An interval of zero produces no request even with enable high. The counter restarts from zero when a nonzero interval is applied.
- R12: After reset, ref_req and ref_active are low and nothing is owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interval | input | CNT_W | Refresh interval in cycles; 0 disables |
| ref_enable | input | 1 | Periodic refresh enable; low clears the counter |
| xfer_busy | input | 1 | A memory transfer is in progress |
| self_ref | input | 1 | Memory is in self-refresh |
| gap_cycles | input | GAP_W | Recovery cycles after done before a new request |
| seq_grant | input | 1 | Sequencer accepts the request |
| seq_done | input | 1 | Sequencer finished Precharge All plus Auto Refresh |
| ref_req | output | 1 | Refresh request to the sequencer |
| ref_active | output | 1 | Refresh granted or in recovery |

## Verification
The hardest state to reach from the ports is the saturated owed count, with expiries arriving while two refreshes are already owed. The bench gets there by holding self_ref high across three interval expiries. It then checks that exactly two requests come out back to back after wake-up, and that the third request lands on the original schedule. Deferral is checked by opening a busy window over one expiry. The scoreboard then expects the following request at the undisturbed time, which shows that the counter never restarted.

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int CNT_W    = 16,
  parameter int GAP_W    = 4,
  parameter int PEND_MAX = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] interval,
  input  logic             ref_enable,
  input  logic             xfer_busy,
  input  logic             self_ref,
  input  logic [GAP_W-1:0] gap_cycles,
  input  logic             seq_grant,
  input  logic             seq_done,
  output logic             ref_req,
  output logic             ref_active
);

  localparam int PEND_W = $clog2(PEND_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RUN, S_RECOV} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [PEND_W-1:0] pend;
  logic [GAP_W-1:0] rcnt;

  wire timer_run = ref_enable && (interval != '0);
  wire expire    = timer_run && (cnt == interval - CNT_W'(1));
  wire take      = (st == S_RUN) && seq_done;
  wire can_ask   = (pend != '0) && !xfer_busy && !self_ref;

  always_ff @(posedge clk) begin
    if (!rst_n || !timer_run) cnt <= '0;
    else if (expire)          cnt <= '0;
    else                      cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else begin
      case ({expire, take})
        2'b10: if (pend != PEND_W'(PEND_MAX)) pend <= pend + PEND_W'(1);
        2'b01: pend <= pend - PEND_W'(1);
        default: pend <= pend;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      rcnt <= '0;
    end else begin
      case (st)
        S_IDLE:  if (can_ask) st <= S_REQ;
        S_REQ:   if (seq_grant) st <= S_RUN;
        S_RUN:
          if (seq_done) begin
            if (gap_cycles != '0) begin
              st   <= S_RECOV;
              rcnt <= gap_cycles;
            end else st <= S_IDLE;
          end
        S_RECOV:
          if (rcnt <= GAP_W'(1)) st <= S_IDLE;
          else rcnt <= rcnt - GAP_W'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ref_req    = (st == S_REQ) || (st == S_RUN);
  assign ref_active = (st == S_RUN) || (st == S_RECOV);

  AST_REQ_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_req) |-> !$past(xfer_busy) && !$past(self_ref)); // R2
  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PEND_W'(PEND_MAX)); // R6
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req && !seq_done |=> ref_req); // R7
  AST_ACTIVE_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_active) |-> $past(seq_grant)); // R8
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_enable |=> cnt == '0); // R10
  AST_ZERO_INTERVAL: assert property (@(posedge clk) disable iff (!rst_n)
    interval == '0 |=> cnt == '0); // R11

endmodule

// File: tb/tb_sdram_refresh_sched.sv
`timescale 1ns/1ps
module tb_sdram_refresh_sched;
  localparam int CNT_W = 16;
  localparam int GAP_W = 4;

  typedef struct { int cyc; string tag; } exp_t;

  logic clk = 0, rst_n = 0;
  logic [CNT_W-1:0] interval = '0;
  logic ref_enable = 0, xfer_busy = 0, self_ref = 0;
  logic [GAP_W-1:0] gap_cycles = '0;
  logic seq_grant = 0, seq_done = 0;
  logic ref_req, ref_active;

  int cyc = 0, total = 0, bad = 0;
  bit sb_on = 0, req_q = 0, finished = 0;
  int phase = 0, j = 0;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_refresh_sched #(.CNT_W(CNT_W), .GAP_W(GAP_W), .PEND_MAX(2)) dut (
    .clk(clk), .rst_n(rst_n), .interval(interval), .ref_enable(ref_enable),
    .xfer_busy(xfer_busy), .self_ref(self_ref), .gap_cycles(gap_cycles),
    .seq_grant(seq_grant), .seq_done(seq_done),
    .ref_req(ref_req), .ref_active(ref_active));

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic expect_rise(int c, string tag);
    exp_t e;
    e.cyc = c; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (sb_on) begin
      if (ref_req && !req_q) begin
        if (q.size() == 0) chk(0, "R1/R11 unexpected request", cyc, -1);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(cyc == e.cyc, e.tag, cyc, e.cyc);
        end
        chk(ref_active == 0, "R8 idle before grant", ref_active, 0);
        seq_grant <= 1;
        phase = 1;
      end else if (phase == 1) begin
        chk(ref_req == 1, "R7 held after grant", ref_req, 1);
        chk(ref_active == 1, "R8 active on grant", ref_active, 1);
        seq_grant <= 0;
        seq_done  <= 1;
        phase = 2; j = 0;
      end else if (phase == 2) begin
        seq_done <= 0;
        chk(ref_req == 0, "R7 drop after done", ref_req, 0);
        chk(ref_active == (j < int'(gap_cycles)), "R8 recovery window",
            ref_active, j < int'(gap_cycles));
        if (j >= int'(gap_cycles)) phase = 0;
        j++;
      end
    end
    req_q = ref_req;
  end

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic start(int iv, int gap, output int m);
    sb_on = 0;
    @(negedge clk);
    rst_n = 0; ref_enable = 0; xfer_busy = 0; self_ref = 0;
    seq_grant = 0; seq_done = 0; phase = 0; q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1;
    interval = CNT_W'(iv); gap_cycles = GAP_W'(gap);
    @(negedge clk);
    chk(ref_req == 0 && ref_active == 0, "R12 reset state", {ref_req, ref_active}, 0);
    req_q = 0; sb_on = 1;
    ref_enable = 1;
    m = cyc + 1;
  endtask

  task automatic finish_scn(int c, string tag);
    wait_to(c);
    chk(q.size() == 0, tag, q.size(), 0);
  endtask

  initial begin
    int m, p;
    // R1, R7, R8 with recovery gap
    start(20, 2, m);
    expect_rise(m + 20, "R1 first"); expect_rise(m + 40, "R1 second");
    expect_rise(m + 60, "R1 third");
    finish_scn(m + 70, "R1 all requests seen");
    // R1 with zero gap
    start(7, 0, m);
    expect_rise(m + 7, "R1 short"); expect_rise(m + 14, "R1 short");
    expect_rise(m + 21, "R1 short");
    finish_scn(m + 25, "R1 short all seen");
    // R2, R3 busy deferral
    start(20, 2, m);
    expect_rise(m + 26, "R2 deferred until free");
    expect_rise(m + 40, "R3 schedule kept");
    wait_to(m + 15); xfer_busy = 1;
    wait_to(m + 25); xfer_busy = 0;
    finish_scn(m + 50, "R2 all seen");
    // R5 short self-refresh stay
    start(20, 2, m);
    expect_rise(m + 20, "R5 on schedule"); expect_rise(m + 40, "R5 on schedule");
    wait_to(m + 3); self_ref = 1;
    wait_to(m + 10); self_ref = 0;
    finish_scn(m + 45, "R5 no extra");
    // R4, R6, R9 saturation across self-refresh
    start(20, 2, m);
    expect_rise(m + 66, "R4 after wake");
    expect_rise(m + 71, "R9 back to back");
    expect_rise(m + 80, "R6 third expiry dropped, schedule kept");
    wait_to(m + 5); self_ref = 1;
    wait_to(m + 65); self_ref = 0;
    finish_scn(m + 90, "R6 exactly two served");
    // R10 disable resets counter
    start(20, 2, m);
    wait_to(m + 12); ref_enable = 0;
    wait_to(m + 16); ref_enable = 1;
    expect_rise(m + 37, "R10 restart from zero");
    expect_rise(m + 57, "R10 period after restart");
    finish_scn(m + 60, "R10 all seen");
    // R11 zero interval
    start(0, 2, m);
    wait_to(m + 100);
    p = cyc;
    interval = CNT_W'(10);
    expect_rise(p + 11, "R11 restart after nonzero interval");
    finish_scn(p + 15, "R11 none while zero");
    sb_on = 0;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule